// File: doc/BRIEF.md
# Integer Multiply/Divide Unit

This unit computes integer products and quotients for an issue stage that hands it one operation at a time over a valid/ready handshake. Each operation carries two operands, a multiply-or-divide select, a signed select, a half select and a destination tag. Each result comes back with the same tag, an error flag and a one-cycle valid pulse. There is no backpressure on the output side.

Multiplies pass through three register stages: operand capture, a partial-product stage, and result select. The middle stage multiplies the first operand by one half-width slice of the second operand per pass. A second operand that fits in a half-width slice needs one pass. A wider one needs two passes, and the second pass adds the upper slice's product, shifted, into the accumulator.

Divides use the same middle stage. They run a restoring shift-subtract loop that produces one quotient bit per cycle. While the loop runs, later operations wait in the capture stage and the ready signal drops. Results therefore always leave in acceptance order.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, inReady is 1 and both outValid and outError are 0.
- R2: An operation is accepted at a rising edge where inValid and inReady are both 1. A one-pass multiply accepted at edge t with the middle stage free shows outValid high for exactly the cycle after edge t+2. Back-to-back one-pass multiplies are accepted on every edge.
- R3: inDiv=0 selects a multiply, which forms the full 64-bit product. inSigned=1 treats both operands as two's complement and inSigned=0 treats them as unsigned. inHigh=1 returns product bits 63:32 and inHigh=0 returns bits 31:0.
- R4: A multiply needs one pass when its second operand fits in 16 bits and two passes otherwise. The operand fits when bits 31:16 are zero (unsigned) or when bits 31:15 are all equal (signed). A two-pass multiply holds the middle stage for two edges: its result appears one edge later than a one-pass result, and the next operation enters the middle stage one edge later.
- R5: inDiv=1 selects an unsigned divide. inHigh=0 returns the quotient and inHigh=1 returns the remainder. inSigned has no effect on a divide.
- R6: A divide holds the middle stage for 32 edges, so its result appears 33 edges after acceptance when the stage was free. While an operation waits in the capture stage behind an unfinished divide or a multiply's first pass, inReady is 0.
- R7: A divide with a zero divisor returns 0 with outError=1 during its outValid cycle. outError is 0 in every other cycle.
- R8: Each accepted operation produces exactly one outValid pulse. The pulses come in acceptance order, and each carries the operation's tag on outTag.
- R9: Nothing is accepted while inValid is 0: operand values presented with inValid low produce no output. An operation held with inValid high while inReady is 0 is accepted once inReady returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Unit can take an operation at the next edge |
| inDiv | input | 1 | 1 = divide, 0 = multiply |
| inSigned | input | 1 | 1 = two's complement multiply |
| inHigh | input | 1 | 1 = upper product half or remainder |
| inA | input | WIDTH | Multiplicand or dividend |
| inB | input | WIDTH | Multiplier or divisor |
| inTag | input | TAG_W | Destination tag |
| outValid | output | 1 | Result valid pulse |
| outResult | output | WIDTH | Result data |
| outTag | output | TAG_W | Tag of the returned result |
| outError | output | 1 | Divide-by-zero flag |

## Verification
A behavioural timing model predicts inReady and outValid cycle by cycle, and these predictions are compared against the unit under several stimulus patterns:
- Streams of back-to-back one-pass multiplies check the full-rate path.
- Second operands just inside and just outside the 16-bit fit rule, in both signednesses, separate one-pass from two-pass handling and expose any sign error in the upper slice.
- Divides followed at once by multiplies, and divides issued back to back, check the stall length and that ordering is kept behind the iteration.
- Zero divisors, unsigned divides with inSigned set, idle gaps carrying junk operands, and a long random mix separate the error path, the unsigned divide rule and spurious acceptance from the normal flow.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  // Per-cycle strobes from the control to the datapath.
  typedef struct packed {
    logic s1Load;   // capture a new operation into stage one
    logic s2Start;  // move stage one into stage two and run the first step
    logic s2Step;   // run a further step on the stage-two contents
    logic s3Load;   // stage two finished, register the result
  } mduStrobe_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output logic       inReady,
  input  logic       s1IsDiv,
  input  logic       s1Short,
  output mduStrobe_t strobe,
  output logic       outValid
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] DIV_PASSES  = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] ONE_PASS    = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_PASSES  = CNT_W'(2);

  logic             s1Valid;
  logic             s2Valid;
  logic [CNT_W-1:0] s2Count;
  logic [CNT_W-1:0] s2Need;
  logic             s2Done;
  logic             s1Advance;
  logic [CNT_W-1:0] passesNeeded;

  always_comb begin
    s2Done         = s2Valid && (s2Count == s2Need);
    s1Advance      = s1Valid && (!s2Valid || s2Done);
    inReady        = !s1Valid || s1Advance;
    strobe.s1Load  = inValid && inReady;
    strobe.s2Start = s1Advance;
    strobe.s2Step  = s2Valid && !s2Done;
    strobe.s3Load  = s2Done;
    if (s1IsDiv)      passesNeeded = DIV_PASSES;
    else if (s1Short) passesNeeded = ONE_PASS;
    else              passesNeeded = TWO_PASSES;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid  <= 1'b0;
      s2Valid  <= 1'b0;
      s2Count  <= '0;
      s2Need   <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobe.s1Load)  s1Valid <= 1'b1;
      else if (s1Advance) s1Valid <= 1'b0;

      if (strobe.s2Start) begin
        s2Valid <= 1'b1;
        s2Count <= ONE_PASS;
        s2Need  <= passesNeeded;
      end else if (strobe.s2Step) begin
        s2Count <= s2Count + ONE_PASS;
      end else if (s2Done) begin
        s2Valid <= 1'b0;
      end

      outValid <= strobe.s3Load;
    end
  end

  // A two-pass multiply cannot finish on the edge after it starts.
  assert_long_mul_two_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.s2Start && !s1IsDiv && !s1Short) |=> (s2Valid && !s2Done));

  // A divide is still iterating on the edge after it starts.
  assert_div_occupies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.s2Start && s1IsDiv) |=> (s2Valid && !s2Done));

  // An operation waiting behind unfinished stage-two work blocks new issue.
  assert_ready_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1Valid && s2Valid && !s2Done) |-> !inReady);

  // A captured operation is never dropped while it waits.
  assert_hold_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1Valid && !s1Advance) |=> s1Valid);

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mduStrobe_t       strobe,
  input  logic [WIDTH-1:0] inA,
  input  logic [WIDTH-1:0] inB,
  input  logic             inDiv,
  input  logic             inSigned,
  input  logic             inHigh,
  input  logic [TAG_W-1:0] inTag,
  output logic             s1IsDiv,
  output logic             s1Short,
  output logic [WIDTH-1:0] outResult,
  output logic [TAG_W-1:0] outTag,
  output logic             outError
);

  localparam int HALF    = WIDTH / 2;
  localparam int ACC_W   = 2 * WIDTH;
  localparam int CHUNK_W = HALF + 1;

  // One restoring shift-subtract step on {remainder, quotient}.
  function automatic logic [ACC_W-1:0] divStep(input logic [ACC_W-1:0] st,
                                               input logic [WIDTH-1:0] d);
    logic [WIDTH:0]   trial;
    logic             ge;
    logic [WIDTH-1:0] rem;
    trial = {st[ACC_W-1:WIDTH], st[WIDTH-1]};
    ge    = (trial >= {1'b0, d});
    rem   = ge ? (trial[WIDTH-1:0] - d) : trial[WIDTH-1:0];
    return {rem, st[WIDTH-2:0], ge};
  endfunction

  // Stage one
  logic [WIDTH-1:0] s1A, s1B;
  logic             s1Signed, s1High;
  logic [TAG_W-1:0] s1Tag;

  // Stage two
  logic [WIDTH-1:0] s2A, s2B;
  logic             s2Div, s2Signed, s2High;
  logic [TAG_W-1:0] s2Tag;
  logic [ACC_W-1:0] acc;

  logic [HALF:0]    upperSlice;
  logic [WIDTH-1:0] mulA;
  logic             mulSgn;
  logic [WIDTH:0]   aExt;
  logic [CHUNK_W-1:0] chunk;
  logic [ACC_W-1:0] aWide, chunkWide, prod, accNext;
  logic             divZero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1A <= '0; s1B <= '0; s1IsDiv <= 1'b0; s1Signed <= 1'b0;
      s1High <= 1'b0; s1Tag <= '0;
    end else if (strobe.s1Load) begin
      s1A      <= inA;
      s1B      <= inB;
      s1IsDiv  <= inDiv;
      s1Signed <= inSigned;
      s1High   <= inHigh;
      s1Tag    <= inTag;
    end
  end

  always_comb begin
    upperSlice = s1B[WIDTH-1:HALF-1];
    if (s1Signed) s1Short = (&upperSlice) || !(|upperSlice);
    else          s1Short = !(|s1B[WIDTH-1:HALF]);

    mulA   = strobe.s2Start ? s1A : s2A;
    mulSgn = strobe.s2Start ? s1Signed : s2Signed;
    if (strobe.s2Start)
      chunk = {s1Signed & s1Short & s1B[HALF-1], s1B[HALF-1:0]};
    else
      chunk = {s2Signed & s2B[WIDTH-1], s2B[WIDTH-1:HALF]};

    aExt      = {mulSgn & mulA[WIDTH-1], mulA};
    aWide     = {{(ACC_W-WIDTH-1){aExt[WIDTH]}}, aExt};
    chunkWide = {{(ACC_W-CHUNK_W){chunk[HALF]}}, chunk};
    prod      = aWide * chunkWide;

    if (strobe.s2Start)
      accNext = s1IsDiv ? divStep({{WIDTH{1'b0}}, s1A}, s1B) : prod;
    else if (s2Div)
      accNext = divStep(acc, s2B);
    else
      accNext = acc + (prod << HALF);

    divZero = s2Div && (s2B == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2A <= '0; s2B <= '0; s2Div <= 1'b0; s2Signed <= 1'b0;
      s2High <= 1'b0; s2Tag <= '0; acc <= '0;
    end else begin
      if (strobe.s2Start) begin
        s2A      <= s1A;
        s2B      <= s1B;
        s2Div    <= s1IsDiv;
        s2Signed <= s1Signed;
        s2High   <= s1High;
        s2Tag    <= s1Tag;
      end
      if (strobe.s2Start || strobe.s2Step) acc <= accNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outResult <= '0;
      outTag    <= '0;
      outError  <= 1'b0;
    end else begin
      outError <= strobe.s3Load && divZero;
      if (strobe.s3Load) begin
        outTag <= s2Tag;
        if (divZero)     outResult <= '0;
        else if (s2High) outResult <= acc[ACC_W-1:WIDTH];
        else             outResult <= acc[WIDTH-1:0];
      end
    end
  end

  // A finished divide leaves a remainder below its divisor.
  assert_div_remainder_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.s3Load && s2Div && (s2B != '0)) |-> (acc[ACC_W-1:WIDTH] < s2B));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inDiv,
  input  logic             inSigned,
  input  logic             inHigh,
  input  logic [WIDTH-1:0] inA,
  input  logic [WIDTH-1:0] inB,
  input  logic [TAG_W-1:0] inTag,
  output logic             outValid,
  output logic [WIDTH-1:0] outResult,
  output logic [TAG_W-1:0] outTag,
  output logic             outError
);

  mduStrobe_t strobe;
  logic       s1IsDiv;
  logic       s1Short;

  mdu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inReady  (inReady),
    .s1IsDiv  (s1IsDiv),
    .s1Short  (s1Short),
    .strobe   (strobe),
    .outValid (outValid)
  );

  mdu_datapath #(.WIDTH(WIDTH), .TAG_W(TAG_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .inA       (inA),
    .inB       (inB),
    .inDiv     (inDiv),
    .inSigned  (inSigned),
    .inHigh    (inHigh),
    .inTag     (inTag),
    .s1IsDiv   (s1IsDiv),
    .s1Short   (s1Short),
    .outResult (outResult),
    .outTag    (outTag),
    .outError  (outError)
  );

  // The error flag, from the datapath, only rises with the control's valid pulse.
  assert_error_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    outError |-> outValid);

endmodule

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inValid, inReady, inDiv, inSigned, inHigh;
  logic [31:0] inA, inB;
  logic [3:0]  inTag;
  logic        outValid, outError;
  logic [31:0] outResult;
  logic [3:0]  outTag;

  always #4 clk = ~clk;  // 125 MHz

  muldiv_unit #(.WIDTH(32), .TAG_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inDiv(inDiv), .inSigned(inSigned), .inHigh(inHigh), .inA(inA), .inB(inB),
    .inTag(inTag), .outValid(outValid), .outResult(outResult), .outTag(outTag),
    .outError(outError)
  );

  typedef struct {
    logic [31:0] a, b;
    bit div, sgn, hi;
    int gap;
  } stim_t;

  typedef struct {
    int          outEdge;
    logic [31:0] r;
    bit          err;
    logic [3:0]  tag;
    bit          div;
  } exp_t;

  stim_t stimQ[$];
  exp_t  expQ[$];
  int    checks = 0;
  int    errors = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic addOp(logic [31:0] a, logic [31:0] b, bit div, bit sgn, bit hi, int gap);
    stim_t s;
    s.a = a; s.b = b; s.div = div; s.sgn = sgn; s.hi = hi; s.gap = gap;
    stimQ.push_back(s);
  endtask

  // Reference arithmetic and pass count from the requirements.
  task automatic calc(stim_t s, output logic [31:0] r, output bit err, output int passes);
    logic [63:0] p;
    bit fits;
    err = 1'b0;
    if (s.div) begin
      passes = 32;                                   // R6
      if (s.b == 0) begin err = 1'b1; r = 32'h0; end // R7
      else r = s.hi ? (s.a % s.b) : (s.a / s.b);     // R5
    end else begin
      if (s.sgn) p = $signed({{32{s.a[31]}}, s.a}) * $signed({{32{s.b[31]}}, s.b});
      else       p = {32'h0, s.a} * {32'h0, s.b};
      r = s.hi ? p[63:32] : p[31:0];                 // R3
      if (s.sgn) fits = (s.b[31:15] == 17'h0) || (s.b[31:15] == 17'h1ffff);
      else       fits = (s.b[31:16] == 16'h0);
      passes = fits ? 1 : 2;                         // R4
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    int edgeCnt, lastE, freeE, idx, gap, tail;
    bit driving, modelReady, expValid, lastDiv;

    // Directed: one-pass multiplies back to back (R2, R3)
    addOp(32'd3, 32'd5, 0, 0, 0, 0);
    addOp(32'hFFFF, 32'hFFFF, 0, 0, 0, 0);
    addOp(32'h12345678, 32'h1234, 0, 0, 1, 0);
    addOp(-32'sd7, 32'd3, 0, 1, 0, 0);
    addOp(-32'sd7, -32'sd3, 0, 1, 1, 0);
    addOp(32'h80000000, 32'hFFFF8000, 0, 1, 1, 0);   // fits signed (R4)
    // Fit boundary, two-pass cases (R4)
    addOp(32'h80000000, 32'hFFFF8000, 0, 0, 1, 0);   // unsigned: two passes
    addOp(32'h00010000, 32'h00010000, 0, 0, 1, 0);
    addOp(32'h7FFFFFFF, 32'h00008000, 0, 1, 0, 0);   // signed: two passes
    addOp(32'hDEADBEEF, 32'h0000FFFF, 0, 0, 1, 0);   // unsigned: one pass
    addOp(32'hDEADBEEF, 32'hCAFEF00D, 0, 1, 1, 0);
    addOp(32'd9, 32'd9, 0, 0, 0, 0);
    // Divides (R5, R6, R7)
    addOp(32'd100, 32'd7, 1, 0, 0, 2);
    addOp(32'd100, 32'd7, 1, 0, 1, 0);
    addOp(32'd11, 32'd2, 0, 0, 0, 0);                // waits behind divide
    addOp(32'hFFFFFFFF, 32'd1, 1, 0, 0, 0);
    addOp(32'd5, 32'd10, 1, 0, 1, 0);
    addOp(32'hFFFFFFF0, 32'd3, 1, 1, 0, 0);          // inSigned ignored
    addOp(32'd7, 32'd0, 1, 0, 0, 3);
    addOp(32'd0, 32'd0, 1, 0, 1, 0);
    addOp(32'h40000000, 32'h00030000, 0, 0, 1, 0);
    // Random mix with idle gaps (R9)
    for (int i = 0; i < 150; i++) begin
      logic [31:0] b;
      int sel;
      sel = $urandom_range(0, 3);
      if (sel == 0)      b = $urandom & 32'hFFFF;
      else if (sel == 1) b = -($urandom & 32'h7FFF);
      else               b = $urandom;
      if ($urandom_range(0, 7) == 0) b = 0;
      addOp($urandom, b, $urandom_range(0, 5) == 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 1) == 1, ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0);
    end

    inValid = 0; inDiv = 0; inSigned = 0; inHigh = 0; inA = 0; inB = 0; inTag = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(inReady === 1'b1, "R1", "inReady after reset", 64'(inReady), 64'd1);
    check(outValid === 1'b0, "R1", "outValid after reset", 64'(outValid), 64'd0);
    check(outError === 1'b0, "R1", "outError after reset", 64'(outError), 64'd0);

    edgeCnt = 0; lastE = 0; freeE = 0; idx = 0; tail = 0;
    driving = 0; lastDiv = 0;
    gap = stimQ[0].gap;

    while (tail < 12) begin
      // Outputs after edge edgeCnt
      expValid = (expQ.size() > 0) && (expQ[0].outEdge == edgeCnt);
      check(outValid === expValid, (expQ.size() == 0) ? "R9" : "R2", "outValid",
            64'(outValid), 64'(expValid));
      if (expValid) begin
        if (outValid) begin
          check(outResult === expQ[0].r, expQ[0].err ? "R7" : (expQ[0].div ? "R5" : "R3"),
                "outResult", 64'(outResult), 64'(expQ[0].r));
          check(outTag === expQ[0].tag, "R8", "outTag", 64'(outTag), 64'(expQ[0].tag));
        end
        check(outError === expQ[0].err, "R7", "outError", 64'(outError), 64'(expQ[0].err));
        void'(expQ.pop_front());
      end else begin
        check(outError === 1'b0, "R7", "outError idle", 64'(outError), 64'd0);
      end

      modelReady = (edgeCnt + 1 >= lastE);
      check(inReady === modelReady, lastDiv ? "R6" : "R4", "inReady",
            64'(inReady), 64'(modelReady));

      if (!driving) begin
        if (idx < stimQ.size() && gap == 0) begin
          inValid  = 1;
          inA      = stimQ[idx].a;
          inB      = stimQ[idx].b;
          inDiv    = stimQ[idx].div;
          inSigned = stimQ[idx].sgn;
          inHigh   = stimQ[idx].hi;
          inTag    = idx[3:0];
          driving  = 1;
        end else begin
          // R9: junk operands with inValid low must not be taken
          inValid = 0;
          inA = $urandom; inB = $urandom; inDiv = $urandom_range(0, 1);
          inSigned = $urandom_range(0, 1); inHigh = $urandom_range(0, 1);
          inTag = 4'($urandom);
          if (gap > 0) gap--;
        end
      end

      @(posedge clk);
      edgeCnt++;
      if (driving && modelReady) begin
        exp_t e;
        int   start, passes;
        start = (edgeCnt + 1 > freeE) ? edgeCnt + 1 : freeE;
        calc(stimQ[idx], e.r, e.err, passes);
        e.outEdge = start + passes;
        e.tag     = idx[3:0];
        e.div     = stimQ[idx].div;
        expQ.push_back(e);
        freeE   = start + passes;
        lastE   = start;
        lastDiv = stimQ[idx].div;
        idx++;
        driving = 0;
        gap = (idx < stimQ.size()) ? stimQ[idx].gap : 0;
      end
      if (idx >= stimQ.size() && expQ.size() == 0 && !driving) tail++;
      @(negedge clk);
    end

    finishRun();
  end

endmodule